// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit is the interrupt register section of an I2C controller. Twelve event sources report into a raw status register. Ten of the sources are sticky: a single-cycle pulse sets the bit, and the bit stays set until software clears it. The other two, receive-full and transmit-empty, are levels that track the FIFO state. A mask register selects which raw bits appear in the masked status. The OR of the masked bits drives one registered interrupt line.

Software clears a sticky bit by reading the clear address that belongs to that source. One further address clears all sticky bits together. When a transmit abort occurs, the unit latches a reason word. That word is wiped by reading the abort clear address or the clear-all address. The register port is a plain read strobe, write strobe and word address, with read data registered one cycle after the read.

Top module: `i2c_irq_unit`

## Requirements
- R1: A sticky source (any bit except 2 and 4) is set in the cycle after `src_in` pulses for it. It stays set until a clear read for that bit. Raw status bit positions are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R2: Raw bits 2 and 4 equal the `src_in` bit from the previous cycle. Clear reads have no effect on them.
- R3: A read of word address 8+i (i = 0..11) clears raw bit i only.
- R4: A read of address 4 clears every sticky raw bit in one cycle.
- R5: If a sticky pulse arrives in the same cycle as a clear read of its bit, the bit stays set.
- R6: Address 0 reads raw AND mask. Address 1 is the read/write mask, bits 11:0.
- R7: `irq` is high exactly when the masked status of the previous cycle was nonzero.
- R8: A pulse on `src_in[6]` ORs `abort_why` into the abort reason register, which is readable at address 3. Reason bits 6 and 8 are never stored. The reason bits are: 0 7-bit address unacked, 1 first 10-bit address byte unacked, 2 second 10-bit address byte unacked, 3 data unacked, 4 general call unacked, 5 read after general call, 7 start byte acked, 9 start byte with restart off, 10 10-bit read with restart off, 11 master disabled, 12 arbitration lost.
- R9: A read of address 14 or address 4 clears the abort reason register. A capture in the same cycle replaces the register contents with the new reason.
- R10: After reset the mask is 0x254 (rx full, tx empty, tx abort, stop seen), and raw status, abort reason, `irq` and `rdata` are zero.
- R11: `rdata` shows the addressed register one cycle after `rd`, and is zero when no read was made. Unmapped and clear addresses read zero. Writes to any address other than 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| rd | input | 1 | read strobe |
| wr | input | 1 | write strobe |
| addr | input | ADDR_W | word address |
| wdata | input | DATA_W | write data |
| rdata | output | DATA_W | registered read data |
| src_in | input | 12 | event pulses for sticky bits, levels for bits 2 and 4 |
| abort_why | input | 13 | abort reason, sampled when src_in[6] pulses |
| irq | output | 1 | registered interrupt line |

## Verification
The assertions assume that the sticky inputs are single-cycle pulses. They also assume that `rd` and `wr` are never high together, that the address is stable while a strobe is active, and that `abort_why` is meaningful only in cycles where bit 6 pulses. The stimulus drives every input at the falling edge for exactly one cycle. It never raises both strobes in the same cycle. It sets the two level bits independently of the pulses, and during the random phase it draws pulses, clear reads and mask writes so that they often land in the same cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NSRC      = 12;
  localparam int ABORT_W   = 13;
  localparam int ABORT_BIT = 6;
  localparam logic [NSRC-1:0]    LEVEL_BITS  = 12'h014;
  localparam logic [NSRC-1:0]    MASK_DEF    = 12'h254;
  localparam logic [ABORT_W-1:0] ABORT_VALID = 13'h1EBF;
  localparam int A_MASKED   = 0;
  localparam int A_MASK     = 1;
  localparam int A_RAW      = 2;
  localparam int A_ABORT    = 3;
  localparam int A_CLR_ALL  = 4;
  localparam int A_CLR_BASE = 8;
endpackage

// File: rtl/irq_bit_cell.sv
module irq_bit_cell #(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic clr,
  output logic q
);
  generate
    if (IS_LEVEL) begin : g_level
      logic unused_clr;
      assign unused_clr = clr;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= src;
      end
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (src) q <= 1'b1;
        else if (clr) q <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture #(
  parameter int          W     = 13,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] why,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] base;
  assign base = clr ? '0 : q;

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= base | (why & VALID);
    else          q <= base;
  end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import i2c_irq_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter int              DATA_W    = 32,
  parameter logic [NSRC-1:0] MASK_INIT = MASK_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NSRC-1:0]     raw,
  input  logic [ABORT_W-1:0]  abort,
  output logic [NSRC-1:0]     clr_vec,
  output logic                clr_abort,
  output logic [NSRC-1:0]     mask_q,
  output logic [DATA_W-1:0]   rdata
);
  logic hit_all;
  assign hit_all = rd && (addr == ADDR_W'(A_CLR_ALL));

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(A_CLR_BASE + i);
    assign clr_vec[i] = hit_all || (rd && (addr == CA));
  end

  assign clr_abort = clr_vec[ABORT_BIT];

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= MASK_INIT;
    else if (wr && (addr == ADDR_W'(A_MASK)))
      mask_q <= wdata[NSRC-1:0];
  end

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (addr == ADDR_W'(A_MASKED))     rmux = DATA_W'(raw & mask_q);
    else if (addr == ADDR_W'(A_MASK))  rmux = DATA_W'(mask_q);
    else if (addr == ADDR_W'(A_RAW))   rmux = DATA_W'(raw);
    else if (addr == ADDR_W'(A_ABORT)) rmux = DATA_W'(abort);
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
    else         rdata <= '0;
  end
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter int              DATA_W    = 32,
  parameter logic [NSRC-1:0] MASK_INIT = MASK_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NSRC-1:0]     src_in,
  input  logic [ABORT_W-1:0]  abort_why,
  output logic                irq
);
  logic [NSRC-1:0]    raw_q;
  logic [NSRC-1:0]    mask_q;
  logic [NSRC-1:0]    clr_vec;
  logic               clr_abort;
  logic [ABORT_W-1:0] abort_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_bit_cell #(.IS_LEVEL(LEVEL_BITS[i])) u_cell (
      .clk (clk),
      .rst (rst),
      .src (src_in[i]),
      .clr (clr_vec[i]),
      .q   (raw_q[i])
    );
  end

  irq_abort_capture #(.W(ABORT_W), .VALID(ABORT_VALID)) u_abort (
    .clk (clk),
    .rst (rst),
    .cap (src_in[ABORT_BIT]),
    .why (abort_why),
    .clr (clr_abort),
    .q   (abort_q)
  );

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_INIT(MASK_INIT)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .rd        (rd),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .raw       (raw_q),
    .abort     (abort_q),
    .clr_vec   (clr_vec),
    .clr_abort (clr_abort),
    .mask_q    (mask_q),
    .rdata     (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw_q & mask_q);
  end
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               rd,
  input logic [ADDR_W-1:0]  addr,
  input logic [NSRC-1:0]    src_in,
  input logic [NSRC-1:0]    raw_q,
  input logic [NSRC-1:0]    mask_q,
  input logic [NSRC-1:0]    clr_vec,
  input logic [ABORT_W-1:0] abort_q,
  input logic               irq
);
  localparam logic [NSRC-1:0] STICKY = ~LEVEL_BITS;

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(raw_q) & STICKY & ~$past(clr_vec) & ~raw_q) == '0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(src_in) & STICKY & ~raw_q) == '0));

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & LEVEL_BITS) == ($past(src_in) & LEVEL_BITS)));

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(A_CLR_ALL) && (src_in & STICKY) == '0)
    |=> ((raw_q & STICKY) == '0));

  // R7
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(raw_q & mask_q))));

  // R9
  abort_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(A_CLR_BASE + ABORT_BIT) && !src_in[ABORT_BIT])
    |=> (abort_q == '0));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd      (rd),
  .addr    (addr),
  .src_in  (src_in),
  .raw_q   (raw_q),
  .mask_q  (mask_q),
  .clr_vec (clr_vec),
  .abort_q (abort_q),
  .irq     (irq)
);

// File: tb/i2c_irq_unit_test.sv
module i2c_irq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [11:0]   pulse = '0, lvl = '0;
  logic [11:0]   src_in;
  logic [12:0]   why = '0;
  logic          irq;

  assign src_in = pulse | lvl;

  i2c_irq_unit uut (
    .clk(clk), .rst(rst), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .abort_why(why), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string phase = "R10";

  // behavioural reference
  logic [11:0] m_raw, m_mask;
  logic [12:0] m_abort;
  logic        m_irq;
  logic [31:0] m_rdata;

  function automatic logic [31:0] rd_value(int a);
    case (a)
      0: return 32'(m_raw & m_mask);
      1: return 32'(m_mask);
      2: return 32'(m_raw);
      3: return 32'(m_abort);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_raw <= 0; m_mask <= 12'h254; m_abort <= 0; m_irq <= 0; m_rdata <= 0;
    end else begin
      logic [11:0] nr;
      logic [12:0] na;
      bit wipe;
      for (int i = 0; i < 12; i++) begin
        if (i == 2 || i == 4) nr[i] = src_in[i];
        else if (src_in[i]) nr[i] = 1'b1;
        else if (rd && (int'(addr) == 4 || int'(addr) == 8 + i)) nr[i] = 1'b0;
        else nr[i] = m_raw[i];
      end
      wipe = rd && (int'(addr) == 4 || int'(addr) == 14);
      na = wipe ? 13'd0 : m_abort;
      if (src_in[6]) na = na | (why & 13'h1EBF);
      m_raw   <= nr;
      m_abort <= na;
      m_irq   <= |(m_raw & m_mask);
      m_rdata <= rd ? rd_value(int'(addr)) : 32'd0;
      if (wr && addr == 5'd1) m_mask <= wdata[11:0];
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp += 2;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s/R7 irq act=%0b exp=%0b", phase, irq, m_irq);
      end
      if (rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s/R11 rdata act=%h exp=%h", phase, rdata, m_rdata);
      end
    end
  end

  task automatic step(bit r, bit w, int a, logic [31:0] d, logic [11:0] p, logic [12:0] y);
    @(negedge clk);
    rd = r; wr = w; addr = AW'(a); wdata = d; pulse = p & ~12'h014; why = y;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_read(int a, logic [31:0] exp, string tag);
    step(1, 0, a, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read addr %0d act=%h exp=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    n_cmp += 2;
    if (irq !== 1'b0 || rdata !== 32'd0) begin
      n_bad++;
      $display("FAIL R10 reset outputs act=%0b/%h exp=0/0", irq, rdata);
    end
    expect_read(1, 32'h254, "R10");
    expect_read(2, 32'h0, "R10");
    expect_read(3, 32'h0, "R10");

    phase = "R1";
    step(0, 0, 0, 0, 12'h221, 0); idle(1);
    expect_read(2, 32'h221, "R1");
    idle(5);
    expect_read(2, 32'h221, "R1");

    phase = "R3";
    expect_read(13, 32'h0, "R3");
    expect_read(2, 32'h201, "R3");

    phase = "R6";
    expect_read(0, 32'h200, "R6");
    step(0, 1, 1, 32'hFFF, 0, 0);
    expect_read(0, 32'h201, "R6");
    expect_read(1, 32'hFFF, "R6");

    phase = "R4";
    expect_read(4, 32'h0, "R4");
    expect_read(2, 32'h0, "R4");

    phase = "R2";
    lvl = 12'h014; idle(2);
    expect_read(2, 32'h014, "R2");
    expect_read(10, 32'h0, "R2");
    expect_read(12, 32'h0, "R2");
    expect_read(4, 32'h0, "R2");
    expect_read(2, 32'h014, "R2");
    lvl = 0; idle(2);
    expect_read(2, 32'h0, "R2");

    phase = "R5";
    step(1, 0, 17, 0, 12'h200, 0); idle(1);
    expect_read(2, 32'h200, "R5");
    step(1, 0, 4, 0, 12'h001, 0); idle(1);
    expect_read(2, 32'h001, "R5");
    expect_read(4, 32'h0, "R5");

    phase = "R8";
    step(0, 0, 0, 0, 12'h040, 13'h0009);
    step(0, 0, 0, 0, 12'h040, 13'h1140); idle(1);
    expect_read(3, 32'h1009, "R8");
    expect_read(2, 32'h040, "R8");

    phase = "R9";
    expect_read(14, 32'h0, "R9");
    expect_read(3, 32'h0, "R9");
    expect_read(2, 32'h0, "R9");
    step(1, 0, 14, 0, 12'h040, 13'h0002); idle(1);
    expect_read(3, 32'h2, "R9");
    expect_read(2, 32'h040, "R9");
    expect_read(4, 32'h0, "R9");
    expect_read(3, 32'h0, "R9");

    phase = "R11";
    step(0, 0, 0, 0, 12'h800, 0);
    step(0, 1, 2, 32'h0, 0, 0);
    step(0, 1, 0, 32'h0, 0, 0);
    step(0, 1, 13, 32'h0, 0, 0);
    expect_read(2, 32'h800, "R11");
    expect_read(1, 32'hFFF, "R11");
    expect_read(31, 32'h0, "R11");
    expect_read(0, 32'h800, "R11");

    phase = "R1_rand";
    for (int c = 0; c < 600; c++) begin
      int sel;
      logic [11:0] p;
      sel = $urandom_range(0, 9);
      p = ($urandom_range(0, 3) == 0) ? 12'($urandom) : 12'h0;
      if ($urandom_range(0, 7) == 0) lvl = 12'($urandom) & 12'h014;
      if (sel < 5)
        step(1, 0, $urandom_range(0, 21), 0, p, 13'($urandom));
      else if (sel == 5)
        step(0, 1, $urandom_range(0, 3), $urandom, p, 13'($urandom));
      else
        step(0, 0, 0, 0, p, 13'($urandom));
    end
    idle(3);
    finish_run();
  end
endmodule